// File: doc/BRIEF.md
# Load-Use Stall and Operand Forwarding Control

This block steers the hazard handling of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each cycle it receives the upper bits of the instruction in decode and a taken-branch signal from execute. From these it decides whether decode must wait for a load, whether the wrongly fetched younger instructions must be thrown away, and which source feeds each ALU operand when an instruction runs in execute. It holds no datapath. It only produces the stall, hold, bubble and flush controls and the two operand-select codes.

To do this it keeps a small shadow of the pipeline. For the instruction in execute it stores the destination register, the register-write flag, the load flag and the operand selects that were worked out in decode. For the instruction in memory it stores the destination register and the write flag. The selects are computed one stage early and registered, so in execute they are a clean flop output. A load whose result is needed by the very next instruction costs one bubble, and the loaded value then comes from the writeback path. Branches are predicted not taken. When a branch resolves as taken, the instruction in decode is turned into a bubble and the fetch/decode register is flushed.

Top module: `hfu_top`

## Requirements
- R1: The instruction fields are decoded by bit position. The opcode is bits 31:26, the first source is bits 25:21 and the second source field is bits 20:16. The destination is bits 15:11 for opcode 000000 (register-register) and bits 20:16 for every other opcode. The register-write flag is set for opcodes 000000 and 100011 (load). The load flag is set only for 100011. Bits 20:16 count as a source only for opcodes 000000, 101011 (store) and 000100 (branch).
- R2: In the same cycle, `stall` is 1 exactly when all of the following hold: no branch is taken; the instruction in execute is a load with a nonzero destination; and that destination equals the first source of the decode instruction, or equals its second source field when that field is a source. `pc_hold` and `ifid_hold` always equal `stall`.
- R3: `bubble` equals `stall` OR `br_taken`. In the cycle after a bubble, the execute slot carries no write flag, no load flag and selects 00 on both operands.
- R4: A stall lasts one cycle. When the same instruction is presented again in the next cycle it is not stalled, and when it reaches execute, every operand that reads the load's destination has select 01.
- R5: Operand-select encoding is 00 for the register file, 10 for the execute/memory result and 01 for the memory/writeback value. When both older instructions match a source, 10 wins.
- R6: An operand whose source matches only the instruction one stage further ahead (memory at decode time) gets select 01.
- R7: A producer whose write flag is clear, or whose destination is register 0, never causes a nonzero select or a stall.
- R8: While `br_taken` is 1: `ifid_flush` is 1, `stall`, `pc_hold` and `ifid_hold` are 0, and the decode instruction enters execute as a bubble. An instruction that follows it therefore sees no forwarding from it.
- R9: While `rst_n` is 0, every output is 0 and the shadow stages are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_hi | input | 21 | Bits 31:11 of the instruction in decode |
| br_taken | input | 1 | Branch in execute resolved taken |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| bubble | output | 1 | Clear the control flags entering execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| fwd_a | output | 2 | Select for ALU operand A of the execute instruction |
| fwd_b | output | 2 | Select for ALU operand B of the execute instruction |

## Verification
The bench sweeps every pairing of four producer kinds (register-register, load, immediate add, store) with four consumer kinds (register-register, store, immediate add, branch). Each pairing is tried with producer destinations and consumer sources drawn from registers 0 to 3, at a distance of one or two instructions, and with or without a taken branch on the consumer. Distance one against distance two separates the 10 and 01 selects. The load against the other producers separates a stall from a forward. Register 0 and the store producer show that no-write producers are ignored. Consumers that read bits 20:16 against those that do not show when the second field really is a source. A further reader issued after each consumer shows whether a flushed or stalled instruction still leaves a trace for forwarding.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
    localparam int RA_W    = 5;
    localparam int OP_W    = 6;
    localparam int INS_MSB = 31;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;
    localparam int N_OPND  = 2;

    localparam logic [OP_W-1:0] OP_ALU = 6'h00;
    localparam logic [OP_W-1:0] OP_LD  = 6'h23;
    localparam logic [OP_W-1:0] OP_ST  = 6'h2B;
    localparam logic [OP_W-1:0] OP_BEQ = 6'h04;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic [RA_W-1:0] dst;
        logic            wr;
        logic            ld;
        fwd_sel_e        fa;
        fwd_sel_e        fb;
    } ex_tag_t;

    typedef struct packed {
        logic [RA_W-1:0] dst;
        logic            wr;
    } mem_tag_t;

    typedef struct packed {
        ex_tag_t  ex;
        mem_tag_t mem;
    } stage_t;
endpackage

// File: rtl/hfu_field_dec.sv
module hfu_field_dec
    import hfu_pkg::*;
(
    input  logic [INS_MSB:RD_LSB] ins,
    output logic [RA_W-1:0]       rs,
    output logic [RA_W-1:0]       rt,
    output logic [RA_W-1:0]       dst,
    output logic                  wr,
    output logic                  ld,
    output logic                  rt_src
);
    logic [OP_W-1:0] op;
    logic [RA_W-1:0] rd;
    logic            is_alu;

    always_comb begin
        op     = ins[INS_MSB -: OP_W];
        rs     = ins[RS_LSB +: RA_W];
        rt     = ins[RT_LSB +: RA_W];
        rd     = ins[RD_LSB +: RA_W];
        is_alu = (op == OP_ALU);
        dst    = is_alu ? rd : rt;
        ld     = (op == OP_LD);
        wr     = is_alu | ld;
        rt_src = is_alu | (op == OP_ST) | (op == OP_BEQ);
    end
endmodule

// File: rtl/hfu_load_hazard.sv
module hfu_load_hazard #(
    parameter int AW = hfu_pkg::RA_W
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] rt,
    input  logic          rt_src,
    input  logic          ex_ld,
    input  logic [AW-1:0] ex_dst,
    input  logic          br_taken,
    output logic          stall
);
    logic hit_rs, hit_rt, live;

    always_comb begin
        live   = ex_ld && (ex_dst != '0);
        hit_rs = (ex_dst == rs);
        hit_rt = rt_src && (ex_dst == rt);
        stall  = !br_taken && live && (hit_rs || hit_rt);
    end
endmodule

// File: rtl/hfu_fwd_pick.sv
module hfu_fwd_pick
    import hfu_pkg::*;
#(
    parameter int AW = RA_W
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exm_dst,
    input  logic          exm_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output fwd_sel_e      sel
);
    logic exm_hit, wb_hit;

    always_comb begin
        exm_hit = exm_wr && (exm_dst != '0) && (exm_dst == src);
        wb_hit  = wb_wr  && (wb_dst  != '0) && (wb_dst  == src);
        if (exm_hit)     sel = SEL_EXM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/hfu_top.sv
module hfu_top
    import hfu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INS_MSB:RD_LSB] dec_hi,
    input  logic                  br_taken,
    output logic                  stall,
    output logic                  pc_hold,
    output logic                  ifid_hold,
    output logic                  bubble,
    output logic                  ifid_flush,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b
);
    logic [RA_W-1:0] f_rs, f_rt, f_dst;
    logic            f_wr, f_ld, f_rt_src;
    logic            stall_w, bubble_w;
    logic [RA_W-1:0] src_v [N_OPND];
    fwd_sel_e        pick  [N_OPND];
    stage_t          st_d, st_q;

    hfu_field_dec u_dec (
        .ins    (dec_hi),
        .rs     (f_rs),
        .rt     (f_rt),
        .dst    (f_dst),
        .wr     (f_wr),
        .ld     (f_ld),
        .rt_src (f_rt_src)
    );

    hfu_load_hazard #(.AW(RA_W)) u_haz (
        .rs       (f_rs),
        .rt       (f_rt),
        .rt_src   (f_rt_src),
        .ex_ld    (st_q.ex.ld),
        .ex_dst   (st_q.ex.dst),
        .br_taken (br_taken),
        .stall    (stall_w)
    );

    assign src_v[0] = f_rs;
    assign src_v[1] = f_rt;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hfu_fwd_pick #(.AW(RA_W)) u_pick (
            .src     (src_v[g]),
            .exm_dst (st_q.ex.dst),
            .exm_wr  (st_q.ex.wr),
            .wb_dst  (st_q.mem.dst),
            .wb_wr   (st_q.mem.wr),
            .sel     (pick[g])
        );
    end

    assign bubble_w = stall_w | br_taken;

    always_comb begin
        st_d         = st_q;
        st_d.mem.dst = st_q.ex.dst;
        st_d.mem.wr  = st_q.ex.wr;
        if (bubble_w) begin
            st_d.ex = '0;
        end else begin
            st_d.ex = '{dst: f_dst, wr: f_wr, ld: f_ld, fa: pick[0], fb: pick[1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall      = stall_w;
    assign pc_hold    = stall_w;
    assign ifid_hold  = stall_w;
    assign bubble     = bubble_w;
    assign ifid_flush = br_taken;
    assign fwd_a      = st_q.ex.fa;
    assign fwd_b      = st_q.ex.fb;

    // R4
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R8
    flush_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!stall && !pc_hold && !ifid_hold));

    // R3
    bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (fwd_a == SEL_RF && fwd_b == SEL_RF && !st_q.ex.wr && !st_q.ex.ld));

    // R5
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_a) && $onehot0(fwd_b));

    // R6
    wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == SEL_WB) |-> ($past(st_q.mem.wr) && $past(st_q.mem.dst) != '0));
endmodule

// File: tb/sim_hfu_top.sv
module sim_hfu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:11] dec_hi;
    logic        br_taken;
    logic        stall, pc_hold, ifid_hold, bubble, ifid_flush;
    logic [1:0]  fwd_a, fwd_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench shadow of the pipeline, kept from the requirements
    logic [4:0] m_ex_dst, m_mem_dst;
    logic       m_ex_wr, m_ex_ld, m_mem_wr;
    int         m_ex_fa, m_ex_fb;
    bit         last_stall;

    localparam logic [31:0] NOP = 32'd0;

    always #2 clk = ~clk;

    hfu_top u0 (
        .clk(clk), .rst_n(rst_n), .dec_hi(dec_hi), .br_taken(br_taken),
        .stall(stall), .pc_hold(pc_hold), .ifid_hold(ifid_hold), .bubble(bubble),
        .ifid_flush(ifid_flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd);
        return {op, rs, rt, rd, 11'd0};
    endfunction

    function automatic logic [5:0] op_of(input int i);
        case (i)
            0:       return 6'h00;
            1:       return 6'h23;
            2:       return 6'h08;
            default: return 6'h2B;
        endcase
    endfunction

    function automatic logic [5:0] cop_of(input int i);
        case (i)
            0:       return 6'h00;
            1:       return 6'h2B;
            2:       return 6'h08;
            default: return 6'h04;
        endcase
    endfunction

    // R5 R6 R7: expected select from the bench shadow
    function automatic int sel_for(input logic [4:0] src);
        if (m_ex_wr && m_ex_dst != 0 && m_ex_dst == src) return 2;
        if (m_mem_wr && m_mem_dst != 0 && m_mem_dst == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(input int v, input bit after_stall);
        if (after_stall) return "R4";
        if (v == 2) return "R5";
        if (v == 1) return "R6";
        return "R7";
    endfunction

    task automatic step(input logic [31:0] ins, input logic br, output bit stalled);
        logic [5:0] op;
        logic [4:0] rs, rt, rd, dst;
        logic       alu, wr, ld, usert;
        bit         e_stall, prev;
        int         fa, fb;
        string      stag;
        @(negedge clk);
        dec_hi   = ins[31:11];
        br_taken = br;
        #1;
        // R1: field positions and opcode classes
        op    = ins[31:26];
        rs    = ins[25:21];
        rt    = ins[20:16];
        rd    = ins[15:11];
        alu   = (op == 6'h00);
        dst   = alu ? rd : rt;
        ld    = (op == 6'h23);
        wr    = alu || ld;
        usert = alu || op == 6'h2B || op == 6'h04;
        e_stall = !br && m_ex_ld && m_ex_dst != 0 &&
                  (m_ex_dst == rs || (usert && m_ex_dst == rt));
        fa = sel_for(rs);
        fb = sel_for(rt);
        prev = last_stall;
        stag = br ? "R8" : (prev ? "R4" : "R1,R2");
        chk(stag, stall, e_stall);
        chk(br ? "R8" : "R2", pc_hold, e_stall);
        chk(br ? "R8" : "R2", ifid_hold, e_stall);
        chk("R3", bubble, e_stall || br);
        chk("R8", ifid_flush, br);
        @(posedge clk);
        #1;
        m_mem_dst = m_ex_dst;
        m_mem_wr  = m_ex_wr;
        if (e_stall || br) begin
            m_ex_dst = 0; m_ex_wr = 0; m_ex_ld = 0; m_ex_fa = 0; m_ex_fb = 0;
        end else begin
            m_ex_dst = dst; m_ex_wr = wr; m_ex_ld = ld; m_ex_fa = fa; m_ex_fb = fb;
        end
        if (e_stall || br) begin
            chk("R3", fwd_a, 0);
            chk("R3", fwd_b, 0);
        end else begin
            chk(sel_tag(m_ex_fa, prev), fwd_a, m_ex_fa);
            chk(sel_tag(m_ex_fb, prev), fwd_b, m_ex_fb);
        end
        last_stall = e_stall;
        stalled    = e_stall;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit s;
        rst_n    = 1'b0;
        br_taken = 1'b0;
        dec_hi   = mk(6'h23, 5'd1, 5'd1, 5'd1) >> 11;
        m_ex_dst = 0; m_ex_wr = 0; m_ex_ld = 0; m_ex_fa = 0; m_ex_fb = 0;
        m_mem_dst = 0; m_mem_wr = 0; last_stall = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state at the ports
        chk("R9", stall, 0);
        chk("R9", pc_hold, 0);
        chk("R9", ifid_hold, 0);
        chk("R9", bubble, 0);
        chk("R9", ifid_flush, 0);
        chk("R9", fwd_a, 0);
        chk("R9", fwd_b, 0);
        rst_n = 1'b1;

        for (int brk = 0; brk < 2; brk++)
        for (int pi = 0; pi < 4; pi++)
        for (int p = 0; p < 4; p++)
        for (int gap = 0; gap < 2; gap++)
        for (int ci = 0; ci < 4; ci++)
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
            step(NOP, 1'b0, s);
            step(NOP, 1'b0, s);
            step(mk(op_of(pi), 5'd7, 5'(p), 5'(p)), 1'b0, s);
            if (gap == 1) step(NOP, 1'b0, s);
            step(mk(cop_of(ci), 5'(a), 5'(b), 5'(a)), brk[0], s);
            if (s) step(mk(cop_of(ci), 5'(a), 5'(b), 5'(a)), 1'b0, s);
            step(mk(6'h00, 5'(a), 5'(a), 5'd9), 1'b0, s);
            if (s) step(mk(6'h00, 5'(a), 5'(a), 5'd9), 1'b0, s);
            step(NOP, 1'b0, s);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule